// File: doc/BRIEF.md
# Handshaked serial link transmitter

This block drives the output wire of a full-duplex, byte-acknowledged serial link. The wire idles low. The host hands it a byte with a load strobe, and the block sends that byte as a data packet. The local receiver asks for an acknowledge with a request strobe, and the block sends a short acknowledge packet on the same wire. Both packet kinds begin with a high start bit. A data packet goes on with a marker 1, eight payload bits least-significant first and a low stop bit. An acknowledge packet goes on with a single 0.

The output-ready flag tells the host when it may load the next byte. It falls as soon as a byte is accepted. It comes back only when two things have happened, in either order: the data packet has been fully shifted out, and the far end has returned an acknowledge, reported to this block by the local receiver as a one-cycle pulse. Bit timing comes from an internal divider of the system clock. A speed-select input halves the divider to double the bit rate, and a timing-enable input can hold the divider and the wire where they are. When an acknowledge and a byte are both waiting for a free wire, the acknowledge goes first.

Top module: `hsk_serial_tx`

## Requirements
- R1: While reset is asserted and after it is released, `line_out` is low and `out_ready` is high; nothing is sent until a byte is loaded or an acknowledge is requested.
- R2: A data packet is, in time order: a high start bit, a 1 marker bit, bits 0 to 7 of the byte (bit 0 first), and a low stop bit, each one bit period long (11 periods). The line is low whenever no packet is in progress.
- R3: An acknowledge packet is a high start bit followed by a low bit, each one bit period long, and then the line returns low unless another packet follows.
- R4: One bit period is SLOW_DIV clock cycles while `fast_sel` is 0 and SLOW_DIV/2 cycles while `fast_sel` is 1 (defaults 10 and 5), with `tick_en` held high.
- R5: On an idle line, a packet's start bit begins no later than one bit period plus one clock cycle after the strobe that asked for it.
- R6: If an acknowledge request and a loaded byte are both waiting when the line becomes free, the acknowledge packet is sent first and the data packet directly after it.
- R7: A load while `out_ready` is high is accepted, and `out_ready` is low in the next cycle. A load while `out_ready` is low is ignored: its byte is never sent.
- R8: `out_ready` rises only after the stop bit of the outstanding byte has ended and an `ack_seen` pulse has arrived since that byte was loaded, in either order. An `ack_seen` pulse while `out_ready` is high has no effect.
- R9: While `tick_en` is low, bit timing stops: the line holds its level and no packet starts.
- R10: An acknowledge requested while a data packet is on the wire is held and sent directly after that packet's stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_sel | input | 1 | 0: slow bit rate, 1: double bit rate |
| tick_en | input | 1 | Bit-timing enable; low freezes the divider and the line |
| tx_byte | input | 8 | Byte to send, captured when the load is accepted |
| tx_load | input | 1 | One-cycle load strobe |
| ack_req | input | 1 | One-cycle request to send an acknowledge packet |
| ack_seen | input | 1 | One-cycle pulse: the far end acknowledged our byte |
| line_out | output | 1 | Serial output line |
| out_ready | output | 1 | High when a new byte may be loaded |

## Verification
The bench decodes the wire at the middle of each bit, so a framing, ordering or bit-order fault shows up as a wrong packet list. Bytes are sent alone, together with a simultaneous acknowledge request (which separates a correct priority from a reversed one), and with an acknowledge requested in the middle of a data packet (which shows that requests are held rather than dropped). Both speeds are used, and the width of a lone acknowledge start bit is measured to pin down the bit period. The `ack_seen` pulse is given before the stop bit, after it, and while no byte is outstanding, which separates the two-condition rule for `out_ready` from a rule based on shifting alone and from one that latches stale pulses.

// File: rtl/hsk_tx_pkg.sv
// Package: shared types for the handshaked serial link transmitter.
// Assumes nothing; holds the packet-kind encoding used by the shifter.
package hsk_tx_pkg;

    // Kind of packet currently occupying the line.
    typedef enum logic [1:0] {
        PK_NONE = 2'd0,
        PK_ACK  = 2'd1,
        PK_DATA = 2'd2
    } pkt_kind_t;

endpackage

// File: rtl/hsk_bit_timer.sv
// Module: hsk_bit_timer
// Divides the system clock into a one-cycle bit tick. The divisor is
// SLOW_DIV, or SLOW_DIV/2 when fast_sel is high. Assumes SLOW_DIV >= 4,
// so that ticks never land on consecutive cycles. While tick_en is low
// the count holds and no tick is produced.
module hsk_bit_timer #(
    parameter int SLOW_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_sel,
    input  logic tick_en,
    output logic tick
);
    localparam int FAST_DIV = SLOW_DIV / 2;
    localparam int CW       = $clog2(SLOW_DIV);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;
    logic          wrap;

    // Pick the terminal count for the selected rate.
    assign limit = fast_sel ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
    assign wrap  = (cnt_q >= limit);
    assign tick  = tick_en && wrap;

    // Advance the divider; a switch to the fast rate above the limit wraps at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= wrap ? '0 : cnt_q + CW'(1);
        end
    end

    // R4: ticks are isolated pulses.
    assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick)
        else $error("bit tick on two consecutive cycles");

    // R9: with timing disabled the divider holds.
    assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt_q))
        else $error("divider moved while timing disabled");

endmodule

// File: rtl/hsk_pkt_queue.sv
// Module: hsk_pkt_queue
// Remembers one pending acknowledge request and one pending data byte
// until the shifter grants them. A new request in the grant cycle stays
// pending. Assumes the shifter never grants data while an acknowledge
// is pending.
module hsk_pkt_queue #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_acc,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              ack_req,
    input  logic              grant_ack,
    input  logic              grant_data,
    output logic              ack_pend,
    output logic              data_pend,
    output logic [DATA_W-1:0] data_hold
);
    // Track the pending acknowledge and data flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_pend  <= 1'b0;
            data_pend <= 1'b0;
        end else begin
            ack_pend  <= (ack_pend & ~grant_ack) | ack_req;
            data_pend <= (data_pend & ~grant_data) | load_acc;
        end
    end

    // Capture the byte when the load is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_hold <= '0;
        end else if (load_acc) begin
            data_hold <= byte_in;
        end
    end

    // R6: data is never granted over a waiting acknowledge.
    assert_ack_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_data |-> !ack_pend)
        else $error("data granted while acknowledge pending");

    // R10: a grant only ever serves something pending.
    assert_grant_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_ack |-> ack_pend) and (grant_data |-> data_pend))
        else $error("grant without pending packet");

endmodule

// File: rtl/hsk_frame_shifter.sv
// Module: hsk_frame_shifter
// Owns the line register. On each bit tick it either shifts out the next
// bit of the current packet or, if the line is free, starts a new packet
// (acknowledge before data) or drives the idle low level. Flags data_done
// at the tick that ends a data packet's stop bit. Assumes tick pulses are
// one cycle wide.
module hsk_frame_shifter
    import hsk_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ack_pend,
    input  logic              data_pend,
    input  logic [DATA_W-1:0] data_in,
    output logic              grant_ack,
    output logic              grant_data,
    output logic              data_done,
    output logic              line_out
);
    localparam int FRAME = DATA_W + 3;
    localparam int SW    = FRAME - 1;
    localparam int RW    = $clog2(FRAME);

    logic [SW-1:0] sh_q;
    logic [RW-1:0] rem_q;
    pkt_kind_t     kind_q;
    logic          free;

    // The line is free at a tick with no bits left of the current packet.
    assign free       = tick && (rem_q == '0);
    assign grant_ack  = free && ack_pend;
    assign grant_data = free && data_pend && !ack_pend;
    assign data_done  = free && (kind_q == PK_DATA);

    // Shift the current packet or start the next one on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_out <= 1'b0;
            sh_q     <= '0;
            rem_q    <= '0;
            kind_q   <= PK_NONE;
        end else if (tick) begin
            if (rem_q != '0) begin
                line_out <= sh_q[0];
                sh_q     <= sh_q >> 1;
                rem_q    <= rem_q - RW'(1);
            end else if (grant_ack) begin
                line_out <= 1'b1;
                sh_q     <= '0;
                rem_q    <= RW'(1);
                kind_q   <= PK_ACK;
            end else if (grant_data) begin
                line_out <= 1'b1;
                sh_q     <= {1'b0, data_in, 1'b1};
                rem_q    <= RW'(FRAME - 1);
                kind_q   <= PK_DATA;
            end else begin
                line_out <= 1'b0;
                kind_q   <= PK_NONE;
            end
        end
    end

    // R4: the line only moves on a bit tick.
    assert_line_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(line_out))
        else $error("line changed between bit ticks");

    // R2: a data packet ends on a low stop bit.
    assert_stop_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        data_done |-> !line_out)
        else $error("stop bit not low");

    // R3: the second bit of an acknowledge is low.
    assert_ack_second_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_ack |=> (line_out && sh_q[0] == 1'b0))
        else $error("acknowledge packet shape wrong");

endmodule

// File: rtl/hsk_ready_track.sv
// Module: hsk_ready_track
// Decides when the host may load a byte. A load is accepted only while
// out_ready is high. After acceptance it waits for both the end of the
// data packet and an acknowledge pulse from the receiver, in either order.
// Acknowledge pulses while out_ready is high are dropped.
module hsk_ready_track (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_load,
    input  logic ack_seen,
    input  logic data_done,
    output logic load_acc,
    output logic out_ready
);
    logic sent_q;
    logic acked_q;

    assign load_acc = tx_load && out_ready;

    // Collect the two completion conditions of the outstanding byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_ready <= 1'b1;
            sent_q    <= 1'b0;
            acked_q   <= 1'b0;
        end else if (load_acc) begin
            out_ready <= 1'b0;
            sent_q    <= 1'b0;
            acked_q   <= 1'b0;
        end else if (!out_ready) begin
            if (data_done) sent_q  <= 1'b1;
            if (ack_seen)  acked_q <= 1'b1;
            if ((sent_q || data_done) && (acked_q || ack_seen)) out_ready <= 1'b1;
        end
    end

    // R7: an accepted load drops ready in the next cycle.
    assert_load_drops_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_acc |=> !out_ready)
        else $error("ready still high after load");

    // R8: ready returns only once the acknowledge has arrived.
    assert_rise_needs_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_ready) |-> $past(acked_q || ack_seen))
        else $error("ready rose without acknowledge");

    // R8: ready returns only once the packet has been sent.
    assert_rise_needs_sent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_ready) |-> $past(sent_q || data_done))
        else $error("ready rose before stop bit ended");

endmodule

// File: rtl/hsk_serial_tx.sv
// Module: hsk_serial_tx (top)
// Transmit side of a byte-acknowledged serial link: sends data packets on
// host loads and acknowledge packets on receiver requests over one line,
// and holds out_ready low until the outstanding byte has been sent and
// acknowledged. Assumes ack_req and ack_seen are one-cycle pulses from
// the local receiver in this clock domain.
module hsk_serial_tx #(
    parameter int SLOW_DIV = 10,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_sel,
    input  logic              tick_en,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_load,
    input  logic              ack_req,
    input  logic              ack_seen,
    output logic              line_out,
    output logic              out_ready
);
    logic              tick;
    logic              load_acc;
    logic              ack_pend;
    logic              data_pend;
    logic [DATA_W-1:0] data_hold;
    logic              grant_ack;
    logic              grant_data;
    logic              data_done;

    hsk_bit_timer #(.SLOW_DIV(SLOW_DIV)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_sel (fast_sel),
        .tick_en  (tick_en),
        .tick     (tick)
    );

    hsk_ready_track u_ready (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_load   (tx_load),
        .ack_seen  (ack_seen),
        .data_done (data_done),
        .load_acc  (load_acc),
        .out_ready (out_ready)
    );

    hsk_pkt_queue #(.DATA_W(DATA_W)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_acc   (load_acc),
        .byte_in    (tx_byte),
        .ack_req    (ack_req),
        .grant_ack  (grant_ack),
        .grant_data (grant_data),
        .ack_pend   (ack_pend),
        .data_pend  (data_pend),
        .data_hold  (data_hold)
    );

    hsk_frame_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .ack_pend   (ack_pend),
        .data_pend  (data_pend),
        .data_in    (data_hold),
        .grant_ack  (grant_ack),
        .grant_data (grant_data),
        .data_done  (data_done),
        .line_out   (line_out)
    );

    // R1: the line is low in the first cycle after reset.
    assert_idle_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!line_out && out_ready))
        else $error("reset state wrong");

endmodule

// File: tb/hsk_serial_tx_tb.sv
// Bench for hsk_serial_tx: decodes the line at mid-bit into a packet list
// and compares it with lists computed from the requirements.
module hsk_serial_tx_tb;
    localparam int SLOW     = 10;
    localparam int FAST     = SLOW / 2;
    localparam int ACK_CODE = 256;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fast_sel;
    logic       tick_en;
    logic [7:0] tx_byte;
    logic       tx_load;
    logic       ack_req;
    logic       ack_seen;
    logic       line_out;
    logic       out_ready;

    int n_checks = 0;
    int n_fail   = 0;
    int per      = SLOW;
    bit mon_busy = 1'b0;
    int got[$];
    int exp_q[$];

    always #5 clk = ~clk;

    hsk_serial_tx #(.SLOW_DIV(SLOW), .DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .fast_sel(fast_sel), .tick_en(tick_en),
        .tx_byte(tx_byte), .tx_load(tx_load), .ack_req(ack_req),
        .ack_seen(ack_seen), .line_out(line_out), .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Bit period in cycles for a speed setting (R4).
    function automatic int period_of(input bit fast);
        return fast ? FAST : SLOW;
    endfunction

    // Latest negedge count at which a start bit may first be seen (R5).
    function automatic int max_start_count(input int p);
        return p + 1;
    endfunction

    // Line monitor: catches a start bit, then samples every bit at mid-period.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && line_out === 1'b1) begin
                bit more;
                mon_busy = 1'b1;
                repeat (per / 2) @(negedge clk);
                more = 1'b1;
                while (more) begin
                    repeat (per) @(negedge clk);
                    if (line_out !== 1'b1) begin
                        got.push_back(ACK_CODE);
                    end else begin
                        int d;
                        d = 0;
                        for (int i = 0; i < 8; i++) begin
                            repeat (per) @(negedge clk);
                            if (line_out === 1'b1) d = d | (1 << i);
                        end
                        repeat (per) @(negedge clk);
                        if (line_out !== 1'b0) d = d | 512;
                        got.push_back(d);
                    end
                    repeat (per) @(negedge clk);
                    more = (line_out === 1'b1);
                end
                mon_busy = 1'b0;
            end
        end
    end

    task automatic load_byte(input int b);
        @(negedge clk);
        tx_byte = 8'(b);
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic request_ack();
        @(negedge clk);
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
    endtask

    task automatic pulse_seen();
        @(negedge clk);
        ack_seen = 1'b1;
        @(negedge clk);
        ack_seen = 1'b0;
    endtask

    task automatic settle();
        repeat (16 * per + 10) @(negedge clk);
        while (mon_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_line_high();
        while (line_out !== 1'b1) @(negedge clk);
    endtask

    task automatic check_list(input string req);
        chk(got.size() == exp_q.size(), req, "packet count", got.size(), exp_q.size());
        for (int i = 0; i < exp_q.size(); i++) begin
            if (i < got.size())
                chk(got[i] == exp_q[i], req, "packet value", got[i], exp_q[i]);
        end
        got.delete();
        exp_q.delete();
    endtask

    task automatic set_speed(input bit fast);
        @(negedge clk);
        fast_sel = fast;
        per = period_of(fast);
    endtask

    // Width in cycles of the next high pulse on the line.
    task automatic high_width(output int w);
        wait_line_high();
        w = 0;
        while (line_out === 1'b1) begin
            w++;
            @(negedge clk);
        end
    endtask

    initial begin
        int w;
        int cnt;
        rst_n = 1'b0; fast_sel = 1'b0; tick_en = 1'b1;
        tx_byte = '0; tx_load = 1'b0; ack_req = 1'b0; ack_seen = 1'b0;
        void'($urandom(32'h1A2B3C4D));
        repeat (5) @(negedge clk);
        chk(line_out === 1'b0, "R1", "line in reset", int'(line_out), 0);
        chk(out_ready === 1'b1, "R1", "ready in reset", int'(out_ready), 1);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk(line_out === 1'b0, "R1", "line idle after reset", int'(line_out), 0);
        chk(got.size() == 0, "R1", "no packet after reset", got.size(), 0);

        // R2 / R7 / R8: single byte, slow rate.
        load_byte(8'hA5);
        chk(out_ready === 1'b0, "R7", "ready after load", int'(out_ready), 0);
        settle();
        exp_q.push_back(8'hA5);
        check_list("R2");
        chk(out_ready === 1'b0, "R8", "ready before ack pulse", int'(out_ready), 0);
        pulse_seen();
        chk(out_ready === 1'b1, "R8", "ready after ack pulse", int'(out_ready), 1);

        // R3 / R4: lone acknowledge, slow rate; start bit width.
        request_ack();
        high_width(w);
        chk(w == SLOW, "R4", "slow bit period", w, SLOW);
        settle();
        exp_q.push_back(ACK_CODE);
        check_list("R3");
        chk(out_ready === 1'b1, "R3", "ready unchanged by ack packet", int'(out_ready), 1);

        // R4: fast rate.
        set_speed(1'b1);
        request_ack();
        high_width(w);
        chk(w == FAST, "R4", "fast bit period", w, FAST);
        settle();
        exp_q.push_back(ACK_CODE);
        check_list("R4");
        load_byte(8'h3C);
        settle();
        exp_q.push_back(8'h3C);
        check_list("R4");
        pulse_seen();

        // R5: start latency at slow rate.
        set_speed(1'b0);
        repeat (3) @(negedge clk);
        load_byte(8'h81);
        cnt = 1;
        while (line_out !== 1'b1 && cnt < 4 * SLOW) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt >= 2 && cnt <= max_start_count(SLOW), "R5", "start latency", cnt, max_start_count(SLOW));
        settle();
        exp_q.push_back(8'h81);
        check_list("R5");
        pulse_seen();

        // R6: simultaneous ack request and load.
        @(negedge clk);
        tx_byte = 8'h5A; tx_load = 1'b1; ack_req = 1'b1;
        @(negedge clk);
        tx_load = 1'b0; ack_req = 1'b0;
        settle();
        exp_q.push_back(ACK_CODE);
        exp_q.push_back(8'h5A);
        check_list("R6");
        pulse_seen();

        // R10: ack requested in the middle of a data packet.
        load_byte(8'hC3);
        wait_line_high();
        repeat (3 * per) @(negedge clk);
        request_ack();
        settle();
        exp_q.push_back(8'hC3);
        exp_q.push_back(ACK_CODE);
        check_list("R10");
        pulse_seen();

        // R7: second load while not ready is ignored.
        load_byte(8'h11);
        repeat (3) @(negedge clk);
        load_byte(8'hEE);
        settle();
        exp_q.push_back(8'h11);
        check_list("R7");
        pulse_seen();
        chk(out_ready === 1'b1, "R7", "ready after ignored load", int'(out_ready), 1);

        // R8: acknowledge pulse before the stop bit.
        load_byte(8'h0F);
        wait_line_high();
        pulse_seen();
        chk(out_ready === 1'b0, "R8", "ready during packet after early ack", int'(out_ready), 0);
        settle();
        chk(out_ready === 1'b1, "R8", "ready after packet with early ack", int'(out_ready), 1);
        exp_q.push_back(8'h0F);
        check_list("R8");

        // R8: stale acknowledge pulse while ready is ignored.
        pulse_seen();
        load_byte(8'hF0);
        settle();
        chk(out_ready === 1'b0, "R8", "stale ack not counted", int'(out_ready), 0);
        pulse_seen();
        chk(out_ready === 1'b1, "R8", "ready after real ack", int'(out_ready), 1);
        exp_q.push_back(8'hF0);
        check_list("R8");

        // R9: timing disabled freezes the line.
        @(negedge clk);
        tick_en = 1'b0;
        load_byte(8'h69);
        repeat (100) @(negedge clk);
        chk(line_out === 1'b0, "R9", "line held while disabled", int'(line_out), 0);
        chk(got.size() == 0, "R9", "no packet while disabled", got.size(), 0);
        tick_en = 1'b1;
        settle();
        exp_q.push_back(8'h69);
        check_list("R9");
        pulse_seen();

        // Random mix: R2, R4, R6, R10 with random bytes and speeds.
        for (int it = 0; it < 30; it++) begin
            int b;
            int mode;
            b = int'($urandom_range(0, 255));
            mode = int'($urandom_range(0, 2));
            set_speed(1'($urandom_range(0, 1)));
            if (mode == 1) begin
                @(negedge clk);
                tx_byte = 8'(b); tx_load = 1'b1; ack_req = 1'b1;
                @(negedge clk);
                tx_load = 1'b0; ack_req = 1'b0;
                exp_q.push_back(ACK_CODE);
                exp_q.push_back(b);
            end else begin
                load_byte(b);
                exp_q.push_back(b);
                if (mode == 2) begin
                    wait_line_high();
                    repeat (int'($urandom_range(1, 8)) * per) @(negedge clk);
                    request_ack();
                    exp_q.push_back(ACK_CODE);
                end
            end
            settle();
            check_list(mode == 0 ? "R2" : (mode == 1 ? "R6" : "R10"));
            chk(out_ready === 1'b0, "R8", "random: ready waits for ack", int'(out_ready), 0);
            pulse_seen();
            chk(out_ready === 1'b1, "R8", "random: ready after ack", int'(out_ready), 1);
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule